// File: doc/BRIEF.md
# Two-Wire Data/Strobe Line Codec

This block sends a serial bit stream over two wires and receives it again. On the transmit side, bits come in through a valid/ready handshake. Each accepted bit goes onto a data wire and a strobe wire. The data wire always shows the current bit. The strobe wire flips only when a bit repeats the one before it. As a result, exactly one wire moves per bit, and the exclusive-OR of the two wires changes once every bit period. The receiver needs no separate clock: the transitions of that exclusive-OR mark the bit boundaries.

The transmitter accepts at most one bit every `DIV` clock cycles. It has two states. In `ENC_OFFER`, `in_ready` is high and the wires hold their value. In `ENC_HOLD`, a counter runs out the rest of the bit period. Its transitions are:
- Offer to Hold, when `in_valid` is seen.
- Offer to Offer, when no bit is offered.
- Hold to Offer, when the period counter expires.

The receiver runs on the same fast local clock. It passes both wires through a synchronizer and compares each synchronized sample with the previous one. It has three states:
- `DEC_WATCH`: no change seen.
- `DEC_EMIT`: exactly one wire changed; a bit is presented.
- `DEC_FAULT`: both wires changed in the same sample.

Every state goes to `DEC_EMIT`, `DEC_FAULT` or `DEC_WATCH` according to the change seen in that sample. The transmit wires and the receive inputs are separate ports, so the link between the two halves is made outside the block.

Top module: `ds_link`

## Requirements
- R1: After reset, `line_d` and `line_s` are both 0, `in_ready` is 1, and `out_valid` and `out_err` are both 0. The transmitter treats the bit sent before reset as 0.
- R2: When `in_valid` and `in_ready` are both high at a rising edge, `line_d` takes the value of `in_bit` from that edge. It keeps that value until the next accepted bit.
- R3: `line_s` toggles on an accepted bit if and only if the bit equals the previously sent bit. Otherwise `line_s` keeps its value.
- R4: Every accepted bit changes exactly one of `line_d` and `line_s`.
- R5: After an accepted bit, `in_ready` stays low for exactly `DIV`-1 cycles and then returns high.
- R6: While no bit is accepted, `line_d` and `line_s` do not change, and `in_ready` stays high once it has returned.
- R7: When exactly one of `rx_d` and `rx_s` changes, the decoder raises `out_valid` for one cycle. During that cycle `out_bit` equals the new value of `rx_d`. The pulse comes `SYNC`+1 rising edges after the first edge that samples the change.
- R8: When `rx_d` and `rx_s` both change between two consecutive samples, the decoder raises `out_err` for one cycle and does not raise `out_valid`.
- R9: Sending 1,0,1,1,0,0,0,1 from reset toggles `line_s` on the 4th, 6th and 7th bits only. Looped back, the decoder recovers the same eight bits.
- R10: With idle gaps of any length between bits, a looped-back stream is recovered in order, with no bit lost or added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock for both halves |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_bit | input | 1 | Bit to transmit |
| in_valid | input | 1 | `in_bit` is offered |
| in_ready | output | 1 | Transmitter can take a bit this cycle |
| line_d | output | 1 | Data wire out |
| line_s | output | 1 | Strobe wire out |
| rx_d | input | 1 | Data wire in (asynchronous) |
| rx_s | input | 1 | Strobe wire in (asynchronous) |
| out_bit | output | 1 | Recovered bit |
| out_valid | output | 1 | One-cycle pulse for each recovered bit |
| out_err | output | 1 | One-cycle pulse when both wires moved together |

## Verification
The bench goes after three corner cases:
- Repeated bits. A transmitter that toggled the wrong wire would move both wires or neither. The decoder would then report errors or drop bits.
- The first bit after reset. A wrong reset value for the previous bit would make the opening strobe move wrongly.
- Idle gaps. A transmitter that did not hold its wires during a gap would produce phantom bits.

The bench also drives both receive wires at once. A decoder that mistook that event for a bit would emit data instead of an error pulse. It also toggles the strobe alone, to confirm that a strobe move yields a bit equal to the unchanged data wire.

// File: rtl/ds_pkg.sv
package ds_pkg;
    typedef enum logic [0:0] {
        ENC_OFFER = 1'b0,
        ENC_HOLD  = 1'b1
    } enc_state_t;

    typedef enum logic [1:0] {
        DEC_WATCH = 2'd0,
        DEC_EMIT  = 2'd1,
        DEC_FAULT = 2'd2
    } dec_state_t;
endpackage

// File: rtl/ds_sync.sv
module ds_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ds_tx.sv
module ds_tx
    import ds_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bit,
    input  logic in_valid,
    output logic in_ready,
    output logic line_d,
    output logic line_s
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 2);

    enc_state_t state, state_nx;
    logic [CW-1:0] cnt;
    logic take;

    assign take = (state == ENC_OFFER) && in_valid;

    always_comb begin
        state_nx = state;
        unique case (state)
            ENC_OFFER: if (in_valid) state_nx = ENC_HOLD;
            ENC_HOLD:  if (cnt == LAST) state_nx = ENC_OFFER;
            default:   state_nx = ENC_OFFER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ENC_OFFER;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (take)                  cnt <= '0;
            else if (state == ENC_HOLD) cnt <= cnt + 1'b1;
        end
    end

    // line_d doubles as the memory of the previous bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_d <= 1'b0;
            line_s <= 1'b0;
        end else if (take) begin
            line_d <= in_bit;
            if (in_bit == line_d) line_s <= ~line_s;
        end
    end

    always_comb begin
        in_ready = (state == ENC_OFFER);
    end

    p_data_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (line_d == $past(in_bit)));

    p_one_wire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=>
            ((line_d != $past(line_d)) != (line_s != $past(line_s))));

    p_ready_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> ($stable(line_d) && $stable(line_s)));

    initial begin
        a_div_r5: assert (DIV >= 2);
    end
endmodule

// File: rtl/ds_rx.sv
module ds_rx
    import ds_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_d,
    input  logic rx_s,
    output logic out_bit,
    output logic out_valid,
    output logic out_err
);
    logic [1:0] cur, prev, moved;
    dec_state_t state, state_nx;
    logic bit_q;

    ds_sync #(.W(2), .STAGES(SYNC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({rx_d, rx_s}),
        .sync_out (cur)
    );

    assign moved = cur ^ prev;

    always_comb begin
        unique case (moved)
            2'b00:        state_nx = DEC_WATCH;
            2'b01, 2'b10: state_nx = DEC_EMIT;
            default:      state_nx = DEC_FAULT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DEC_WATCH;
            prev  <= 2'b00;
            bit_q <= 1'b0;
        end else begin
            state <= state_nx;
            prev  <= cur;
            if (state_nx == DEC_EMIT) bit_q <= cur[1];
        end
    end

    always_comb begin
        out_valid = 1'b0;
        out_err   = 1'b0;
        unique case (state)
            DEC_WATCH: ;
            DEC_EMIT:  out_valid = 1'b1;
            DEC_FAULT: out_err   = 1'b1;
            default:   ;
        endcase
        out_bit = bit_q;
    end

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_err));

    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: rtl/ds_link.sv
module ds_link #(
    parameter int DIV  = 4,
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bit,
    input  logic in_valid,
    output logic in_ready,
    output logic line_d,
    output logic line_s,
    input  logic rx_d,
    input  logic rx_s,
    output logic out_bit,
    output logic out_valid,
    output logic out_err
);
    ds_tx #(.DIV(DIV)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_bit   (in_bit),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .line_d   (line_d),
        .line_s   (line_s)
    );

    ds_rx #(.SYNC(SYNC)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_d      (rx_d),
        .rx_s      (rx_s),
        .out_bit   (out_bit),
        .out_valid (out_valid),
        .out_err   (out_err)
    );
endmodule

// File: tb/sim_ds_link.sv
`timescale 1ns/1ps
module sim_ds_link;
    localparam int DIV  = 4;
    localparam int SYNC = 2;
    localparam int MAXB = 256;

    // {bit, strobe expected to move}
    localparam logic [1:0] VEC [8] = '{2'b10, 2'b00, 2'b10, 2'b11,
                                       2'b00, 2'b01, 2'b01, 2'b10};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_bit = 1'b0, in_valid = 1'b0;
    logic in_ready, line_d, line_s;
    logic loop_en = 1'b1, fd = 1'b0, fs = 1'b0;
    logic rx_d, rx_s;
    logic out_bit, out_valid, out_err;

    int checks = 0, fails = 0;
    int nsent = 0, ngot = 0, nerr = 0, cyc = 0;
    logic sent [MAXB];
    logic got  [MAXB];

    always #4 clk = ~clk;

    assign rx_d = loop_en ? line_d : fd;
    assign rx_s = loop_en ? line_s : fs;

    ds_link #(.DIV(DIV), .SYNC(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid),
        .in_ready(in_ready), .line_d(line_d), .line_s(line_s),
        .rx_d(rx_d), .rx_s(rx_s), .out_bit(out_bit),
        .out_valid(out_valid), .out_err(out_err)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (ngot < MAXB) got[ngot] = out_bit;
            ngot++;
        end
        if (rst_n && out_err) nerr++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // offer one bit, check the wires and the ready gap
    task automatic send(input logic b, input int smove_exp);
        logic pd, ps;
        int gap;
        while (!in_ready) @(negedge clk);
        pd = line_d; ps = line_s;
        in_bit = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(line_d == b, "R2 data wire", line_d, b);
        chk((line_d != pd) != (line_s != ps), "R4 one wire",
            int'(line_d != pd) + int'(line_s != ps), 1);
        if (smove_exp >= 0)
            chk(int'(line_s != ps) == smove_exp, "R3 strobe move", line_s != ps, smove_exp);
        else
            chk((line_s != ps) == (b == pd), "R3 strobe rule", line_s != ps, b == pd);
        if (nsent < MAXB) sent[nsent] = b;
        nsent++;
        gap = 0;
        while (!in_ready && gap < 4 * DIV) begin
            gap++;
            @(negedge clk);
        end
        chk(gap == DIV - 1, "R5 ready gap", gap, DIV - 1);
    endtask

    task automatic idle(input int n);
        logic pd, ps;
        pd = line_d; ps = line_s;
        for (int i = 0; i < n; i++) @(negedge clk);
        chk(line_d == pd && line_s == ps && in_ready, "R6 idle hold",
            {line_d, line_s, in_ready}, {pd, ps, 1'b1});
    endtask

    task automatic compare_stream(input string req);
        repeat (SYNC + 6) @(negedge clk);
        chk(ngot == nsent, req, ngot, nsent);
        for (int i = 0; i < nsent && i < MAXB; i++)
            if (i < ngot) chk(got[i] == sent[i], req, got[i], sent[i]);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        int v0, e0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(line_d == 0 && line_s == 0, "R1 wires", {line_d, line_s}, 0);
        chk(in_ready == 1, "R1 ready", in_ready, 1);
        chk(out_valid == 0 && out_err == 0, "R1 outputs", {out_valid, out_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_d == 0 && line_s == 0 && in_ready, "R1 after release",
            {line_d, line_s, in_ready}, 1);

        // R9 vector table walk
        for (int i = 0; i < 8; i++) send(VEC[i][1], int'(VEC[i][0]));
        compare_stream("R9 loopback");
        chk(nerr == 0, "R9 no error", nerr, 0);

        // R6 long idle with no valid
        idle(20);

        // R10 pseudo-random stream with gaps
        lfsr = 16'hACE1;
        for (int i = 0; i < 120; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr[0], -1);
            if (lfsr[3:2] != 2'b00) idle(int'(lfsr[3:2]));
        end
        compare_stream("R10 stream");
        chk(nerr == 0, "R10 no error", nerr, 0);

        // direct receiver drive
        fd = line_d; fs = line_s;
        @(negedge clk);
        loop_en = 1'b0;
        repeat (SYNC + 4) @(negedge clk);
        v0 = ngot; e0 = nerr;
        // R8 both wires move together
        fd = ~fd; fs = ~fs;
        repeat (SYNC + 5) @(negedge clk);
        chk(nerr == e0 + 1, "R8 error pulse", nerr - e0, 1);
        chk(ngot == v0, "R8 no valid", ngot - v0, 0);
        // R7 strobe alone moves: bit equals data wire
        v0 = ngot;
        fs = ~fs;
        repeat (SYNC + 5) @(negedge clk);
        chk(ngot == v0 + 1, "R7 one pulse", ngot - v0, 1);
        chk(out_bit == fd, "R7 bit value", out_bit, fd);
        // R7 data alone moves
        v0 = ngot;
        fd = ~fd;
        repeat (SYNC + 5) @(negedge clk);
        chk(ngot == v0 + 1, "R7 data pulse", ngot - v0, 1);
        chk(out_bit == fd, "R7 data value", out_bit, fd);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule